// File: doc/BRIEF.md
# NAND Byte Bus Bridge

This block turns single-byte host reads and writes into the pin activity of a raw 8-bit NAND flash. Three bits of each host address choose how the byte is presented. Bit 3 raises the command latch enable and bit 2 raises the address latch enable. Bit 4 asserts the chip enable of the selected device. A byte written with only bit 4 set is plain data. The host therefore issues commands, address cycles and data transfers as ordinary byte stores and loads. It needs no separate sequencing engine.

Every access walks through fixed phases: an optional setup, the strobe, a data hold (writes only) and a recovery. Each phase lasts a number of clock cycles. These counts come from a timing word stored per chip select. Software picks each count as the smallest number of bus clocks that covers the slower of the two flash parameters that phase protects. While an access is in flight the host port holds its ready low. A small configuration port holds a control word and one timing word per chip select. A status word reports the synchronised ready/busy pin and a write-complete flag.

Top module: `nand_byte_bridge`

## Requirements
- R1: During the setup, strobe and hold phases, `nand_cle` equals address bit 3 and `nand_ale` equals address bit 2. The selected chip enable is active only when address bit 4 was set. Both bits may be set together.
- R2: A write holds `nand_we_n` low for the timing word's write-wait count (bits 9:8). A value of 0 counts as 1. Throughout the strobe, `nand_dq_oe` is 1 and `nand_dq_out` carries the host byte.
- R3: After `nand_we_n` rises on a write, `nand_dq_oe` stays 1 for exactly the hold count (bits 5:4). Reads have no hold phase.
- R4: After the host access is taken, `host_ready` stays low for setup + strobe + hold + recovery cycles. The recovery count is in bits 3:2. No strobe falls while `host_ready` is high.
- R5: Bit 22 of the timing word adds one setup cycle before the strobe. In that cycle the latch and chip enables are already asserted and both strobes are high.
- R6: A read holds `nand_re_n` low for the read-wait count (bits 7:6). A value of 0 counts as 1. The flash bus is sampled in the last strobe cycle. In the first cycle with `host_ready` high again, `host_rvalid` pulses for one cycle with that byte on `host_rdata`.
- R7: Config offset 0x00 is the control word. Offsets 0x20 and 0x24 hold the timing words of chip selects 0 and 1. Control bits 9:8 choose the chip select: the `nand_ce` pin it drives and the timing word it uses.
- R8: Control bit 4 set makes the chip enable pins active-low (idle 1). When it is clear they are active-high (idle 0).
- R9: `bus_status` bit 0 follows `nand_rb_n` after two clock edges. Bit 3 is set when a write access completes and is cleared when the next access is taken. Bits 2:1 read 0.
- R10: With control bit 0 (enable) clear, host accesses are taken at once with no strobe. Writes are dropped. A read returns 0x00 with `host_rvalid` in the next cycle.
- R11: `nand_we_n` and `nand_re_n` are never low together, and only the strobe that matches the access direction moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Bridge idle; a request is taken on valid and ready |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 5 | Access address; bits 4:2 pick chip enable, CLE, ALE |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte |
| host_rvalid | output | 1 | One-cycle read-return pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write word |
| bus_status | output | 4 | Bit 0 ready/busy, bit 3 write complete |
| nand_ce | output | 2 | Chip enable per chip select, polarity per R8 |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Flash data bus, driven value |
| nand_dq_oe | output | 1 | Flash data bus drive enable |
| nand_dq_in | input | 8 | Flash data bus, sampled value |
| nand_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
On every cycle the assertions check three things. The two strobes never overlap. The write strobe lasts exactly its programmed width, and data stays driven when a hold phase follows it. The read-return pulse, the strobe start and the write-complete clear also hold their relation to the host handshake. The bench's scenarios show the properties that need a chosen timing word or control setting. These are the total stall length per phase mix, the extra setup cycle, the latch-enable decode and the routing to the second chip select. They also cover chip-enable polarity, the two-edge ready/busy delay and the disabled-mode short path.

// File: rtl/nand_bridge_pkg.sv
// Package: shared phase encoding and timing-word layout for the NAND byte bridge.
// Assumes timing counts are two bits wide, as the field positions fix them.
package nand_bridge_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic       setup_en;
        logic [1:0] wr_wait;
        logic [1:0] rd_wait;
        logic [1:0] hold;
        logic [1:0] recov;
    } timing_t;

    // Field positions inside a 32-bit timing word
    localparam int TW_RECOV_LSB = 2;
    localparam int TW_HOLD_LSB  = 4;
    localparam int TW_RD_LSB    = 6;
    localparam int TW_WR_LSB    = 8;
    localparam int TW_SETUP_BIT = 22;

    // Unpack a timing word into its phase counts
    function automatic timing_t unpack_timing(input logic [31:0] w);
        timing_t t;
        t.setup_en = w[TW_SETUP_BIT];
        t.wr_wait  = w[TW_WR_LSB +: 2];
        t.rd_wait  = w[TW_RD_LSB +: 2];
        t.hold     = w[TW_HOLD_LSB +: 2];
        t.recov    = w[TW_RECOV_LSB +: 2];
        return t;
    endfunction

endpackage

// File: rtl/nbb_cfg_regs.sv
// Module: configuration store. Holds the control word and one timing word per
// chip select, and presents the timing of the currently selected chip select.
// Assumes byte offsets: control at 0x00, timing words from 0x20 at a 4-byte stride.
module nbb_cfg_regs
    import nand_bridge_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [5:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic            nand_en,
    output logic            ce_low,
    output logic [CS_W-1:0] cs_sel,
    output timing_t         tim_sel
);
    localparam logic [5:0] CTRL_OFS = 6'h00;
    localparam logic [5:0] TIM_BASE = 6'h20;

    timing_t tim_r [NUM_CS];

    // Control word: enable, chip-enable polarity, chip-select choice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nand_en <= 1'b0;
            ce_low  <= 1'b0;
            cs_sel  <= '0;
        end else if (cfg_we && cfg_addr == CTRL_OFS) begin
            nand_en <= cfg_wdata[0];
            ce_low  <= cfg_wdata[4];
            cs_sel  <= cfg_wdata[8 +: CS_W];
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_tim
        localparam logic [5:0] OFS = TIM_BASE + 6'(4 * i);
        // Timing word of chip select i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tim_r[i] <= '0;
            end else if (cfg_we && cfg_addr == OFS) begin
                tim_r[i] <= unpack_timing(cfg_wdata);
            end
        end
    end

    // Select the timing of the chosen chip select
    always_comb begin
        tim_sel = tim_r[0];
        for (int i = 0; i < NUM_CS; i++) begin
            if (cs_sel == CS_W'(i)) tim_sel = tim_r[i];
        end
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[31:23], cfg_wdata[21:10], cfg_wdata[1]};

endmodule

// File: rtl/nbb_strobe_seq.sv
// Module: access sequencer. Takes one host byte access at a time and walks it
// through setup, strobe, hold and recovery phases sized by the latched timing.
// Assumes the timing and chip select seen at acceptance stay in force for the access.
module nbb_strobe_seq
    import nand_bridge_pkg::*;
#(
    parameter int CS_W = 1,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [2:0]      req_sel,     // {chip enable, CLE, ALE} request bits
    input  logic [DW-1:0]   req_wdata,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_valid,
    input  logic            nand_en,
    input  timing_t         tim,
    input  logic [CS_W-1:0] cs_sel,
    output logic [CS_W-1:0] cs_act,
    output logic            ce_act,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic [DW-1:0]   dq_out,
    output logic            dq_oe,
    input  logic [DW-1:0]   dq_in,
    output logic            accept,
    output logic            wr_done
);
    phase_e          state, state_n;
    logic [1:0]      cnt, cnt_n;
    logic            wr_q;
    logic [2:0]      sel_q;
    logic [DW-1:0]   data_q;
    timing_t         tim_q;
    logic            pins_on;
    logic            ending;

    // Strobe width minus one: a zero count still gives one cycle
    function automatic logic [1:0] strobe_m1(input timing_t t, input logic w);
        logic [1:0] c;
        c = w ? t.wr_wait : t.rd_wait;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    assign req_ready = (state == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign ending    = (state != PH_IDLE) && (state_n == PH_IDLE);
    assign wr_done   = ending && wr_q;

    // Next phase and its remaining-cycle count
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            PH_IDLE: begin
                if (accept && nand_en) begin
                    if (tim.setup_en) begin
                        state_n = PH_SETUP;
                        cnt_n   = 2'd0;
                    end else begin
                        state_n = PH_STROBE;
                        cnt_n   = strobe_m1(tim, req_write);
                    end
                end
            end
            PH_SETUP: begin
                state_n = PH_STROBE;
                cnt_n   = strobe_m1(tim_q, wr_q);
            end
            PH_STROBE: begin
                if (cnt != 2'd0) begin
                    cnt_n = cnt - 2'd1;
                end else if (wr_q && tim_q.hold != 2'd0) begin
                    state_n = PH_HOLD;
                    cnt_n   = tim_q.hold - 2'd1;
                end else if (tim_q.recov != 2'd0) begin
                    state_n = PH_RECOV;
                    cnt_n   = tim_q.recov - 2'd1;
                end else begin
                    state_n = PH_IDLE;
                end
            end
            PH_HOLD: begin
                if (cnt != 2'd0) begin
                    cnt_n = cnt - 2'd1;
                end else if (tim_q.recov != 2'd0) begin
                    state_n = PH_RECOV;
                    cnt_n   = tim_q.recov - 2'd1;
                end else begin
                    state_n = PH_IDLE;
                end
            end
            PH_RECOV: begin
                if (cnt != 2'd0) cnt_n = cnt - 2'd1;
                else             state_n = PH_IDLE;
            end
            default: state_n = PH_IDLE;
        endcase
    end

    // Phase register and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= 2'd0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Latch the request and its timing at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            sel_q  <= '0;
            data_q <= '0;
            tim_q  <= '0;
            cs_act <= '0;
        end else if (accept) begin
            wr_q   <= req_write;
            sel_q  <= req_sel;
            data_q <= req_wdata;
            tim_q  <= tim;
            cs_act <= cs_sel;
        end
    end

    // Read capture at the last strobe cycle, and the return pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= (ending && !wr_q) || (accept && !nand_en && !req_write);
            if (state == PH_STROBE && cnt == 2'd0 && !wr_q) rsp_rdata <= dq_in;
            else if (accept && !nand_en)                     rsp_rdata <= '0;
        end
    end

    assign pins_on = (state == PH_SETUP) || (state == PH_STROBE) || (state == PH_HOLD);
    assign ce_act  = pins_on && sel_q[2];
    assign cle     = pins_on && sel_q[1];
    assign ale     = pins_on && sel_q[0];
    assign we_n    = !(state == PH_STROBE && wr_q);
    assign re_n    = !(state == PH_STROBE && !wr_q);
    assign dq_oe   = pins_on && wr_q;
    assign dq_out  = data_q;

    // Checker state: length of the current write strobe
    logic [2:0] we_run;
    always_ff @(posedge clk) begin
        if (!rst_n)     we_run <= 3'd0;
        else if (!we_n) we_run <= we_run + 3'd1;
        else            we_run <= 3'd0;
    end

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run == ((tim_q.wr_wait == 2'd0) ? 3'd1 : {1'b0, tim_q.wr_wait})));

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && tim_q.hold != 2'd0) |-> dq_oe);

    assert_strobe_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) || $fell(re_n)) |-> !req_ready);

    assert_rvalid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

// File: rtl/nbb_status.sv
// Module: status word. Synchronises the flash ready/busy pin over two flops and
// keeps a sticky write-complete flag that the next accepted access clears.
// Assumes accept and write completion never coincide.
module nbb_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rb_n,
    input  logic       accept,
    input  logic       wr_done,
    output logic [3:0] status
);
    logic rb_s1, rb_s2, wc;

    // Two-stage synchroniser for the ready/busy pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_s1 <= 1'b0;
            rb_s2 <= 1'b0;
        end else begin
            rb_s1 <= rb_n;
            rb_s2 <= rb_s1;
        end
    end

    // Sticky write-complete flag
    always_ff @(posedge clk) begin
        if (!rst_n)       wc <= 1'b0;
        else if (accept)  wc <= 1'b0;
        else if (wr_done) wc <= 1'b1;
    end

    assign status = {wc, 2'b00, rb_s2};

    assert_wc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !status[3]);

    assert_wc_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> status[3]);

endmodule

// File: rtl/nand_byte_bridge.sv
// Module: top of the NAND byte bridge. Joins the configuration store, the access
// sequencer and the status word, and applies chip-enable routing and polarity.
// Assumes the flash data bus tri-state is resolved outside, using nand_dq_oe.
module nand_byte_bridge
    import nand_bridge_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [4:0]        host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_rvalid,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [3:0]        bus_status,
    output logic [NUM_CS-1:0] nand_ce,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DW-1:0]     nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DW-1:0]     nand_dq_in,
    input  logic              nand_rb_n
);
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic            nand_en, ce_low, ce_act, accept, wr_done;
    logic [CS_W-1:0] cs_sel, cs_act;
    timing_t         tim_sel;

    nbb_cfg_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .nand_en   (nand_en),
        .ce_low    (ce_low),
        .cs_sel    (cs_sel),
        .tim_sel   (tim_sel)
    );

    nbb_strobe_seq #(.CS_W(CS_W), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (host_valid),
        .req_ready (host_ready),
        .req_write (host_write),
        .req_sel   (host_addr[4:2]),
        .req_wdata (host_wdata),
        .rsp_rdata (host_rdata),
        .rsp_valid (host_rvalid),
        .nand_en   (nand_en),
        .tim       (tim_sel),
        .cs_sel    (cs_sel),
        .cs_act    (cs_act),
        .ce_act    (ce_act),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_out    (nand_dq_out),
        .dq_oe     (nand_dq_oe),
        .dq_in     (nand_dq_in),
        .accept    (accept),
        .wr_done   (wr_done)
    );

    nbb_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .rb_n    (nand_rb_n),
        .accept  (accept),
        .wr_done (wr_done),
        .status  (bus_status)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
        // Chip enable i: active only for the latched chip select, then polarity
        assign nand_ce[i] = (ce_act && cs_act == CS_W'(i)) ^ ce_low;
    end

    logic unused_addr_bits;
    assign unused_addr_bits = ^host_addr[1:0];

    assert_ce_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nand_ce ^ {NUM_CS{ce_low}}));

endmodule

// File: tb/nand_byte_bridge_bench.sv
module nand_byte_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  bus_status;
    logic [1:0]  nand_ce;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nand_byte_bridge u_nand_byte_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bus_status(bus_status), .nand_ce(nand_ce), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb_n(nand_rb_n)
    );

    typedef struct packed {
        logic       wr;
        logic [4:0] addr;
        logic [7:0] data;
        logic       setup;
        logic [1:0] twr, trd, thold, trec;
        logic [3:0] busy, strobe;
        logic       cle, ale;
    } vec_t;

    // Expected busy = setup + max(wait,1) + (write ? hold : 0) + recovery
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h18, 8'h70, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1, 4'd1, 1'b1, 1'b0},
        '{1'b1, 5'h14, 8'hA5, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1, 4'd4, 4'd2, 1'b0, 1'b1},
        '{1'b1, 5'h10, 8'h3C, 1'b1, 2'd3, 2'd1, 2'd3, 2'd2, 4'd9, 4'd3, 1'b0, 1'b0},
        '{1'b0, 5'h10, 8'h5A, 1'b0, 2'd0, 2'd2, 2'd2, 2'd1, 4'd3, 4'd2, 1'b0, 1'b0},
        '{1'b0, 5'h10, 8'hC3, 1'b1, 2'd1, 2'd3, 2'd0, 2'd3, 4'd7, 4'd3, 1'b0, 1'b0},
        '{1'b0, 5'h10, 8'h81, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1, 4'd1, 1'b0, 1'b0},
        '{1'b1, 5'h1C, 8'h00, 1'b0, 2'd1, 2'd0, 2'd2, 2'd0, 4'd3, 4'd1, 1'b1, 1'b1}
    };

    int         m_busy, m_pre, m_strobe, m_post_oe, m_wrong;
    logic       m_cle, m_ale, m_oe, m_rvalid;
    logic [1:0] m_ce;
    logic [7:0] m_dq, m_rdata;
    logic [3:0] m_status;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] tword(input logic s, input logic [1:0] w,
                                          input logic [1:0] r, input logic [1:0] h,
                                          input logic [1:0] c);
        return (32'(s) << 22) | (32'(w) << 8) | (32'(r) << 6) | (32'(h) << 4) | (32'(c) << 2);
    endfunction

    // One host access; measures the pin activity at each falling edge
    task automatic run_access(input logic wr, input logic [4:0] a, input logic [7:0] d,
                              input logic [7:0] flash);
        bit seen = 0;
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d; nand_dq_in = flash;
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        m_busy = 0; m_pre = 0; m_strobe = 0; m_post_oe = 0; m_wrong = 0;
        m_cle = 1'b0; m_ale = 1'b0; m_oe = 1'b0; m_ce = nand_ce; m_dq = '0;
        while (!host_ready && m_busy < 40) begin
            m_busy++;
            if (wr ? !nand_re_n : !nand_we_n) m_wrong++;
            if (wr ? !nand_we_n : !nand_re_n) begin
                if (!seen) begin
                    m_cle = nand_cle; m_ale = nand_ale; m_ce = nand_ce;
                    m_dq = nand_dq_out; m_oe = nand_dq_oe;
                end
                seen = 1;
                m_strobe++;
            end else if (!seen) begin
                m_pre++;
                if (m_pre == 1) begin
                    m_cle = nand_cle; m_ale = nand_ale; m_ce = nand_ce;
                end
            end else if (nand_dq_oe) begin
                m_post_oe++;
            end
            @(negedge clk);
        end
        m_rvalid = host_rvalid; m_rdata = host_rdata; m_status = bus_status;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state
        check(host_ready == 1'b1, "R4 ready in reset", host_ready, 1);
        check(nand_we_n && nand_re_n, "R11 strobes idle in reset", {nand_we_n, nand_re_n}, 3);
        check(nand_ce == 2'b00, "R8 ce inactive high-polarity reset", nand_ce, 0);
        check(bus_status == 4'h0, "R9 status in reset", bus_status, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_status[0] == 1'b1, "R9 ready bit after reset", bus_status[0], 1);

        // Table walk: chip select 0, active-low chip enables
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            cfg_write(6'h20, tword(v.setup, v.twr, v.trd, v.thold, v.trec));
            cfg_write(6'h00, 32'h0000_0011);
            run_access(v.wr, v.addr, v.data, v.data);
            check(m_busy == int'(v.busy), "R4 busy cycles", m_busy, v.busy);
            check(m_strobe == int'(v.strobe), v.wr ? "R2 we width" : "R6 re width", m_strobe, v.strobe);
            check(m_pre == int'(v.setup), "R5 setup cycles", m_pre, v.setup);
            check(m_cle == v.cle && m_ale == v.ale, "R1 latch enables", {m_cle, m_ale}, {v.cle, v.ale});
            check(m_ce == 2'b10, "R1 ce0 active low", m_ce, 2);
            check(m_wrong == 0, "R11 opposite strobe quiet", m_wrong, 0);
            if (v.wr) begin
                check(m_oe && m_dq == v.data, "R2 write data on bus", m_dq, v.data);
                check(m_post_oe == int'(v.thold), "R3 hold cycles", m_post_oe, v.thold);
                check(m_status[3] == 1'b1, "R9 write complete set", m_status[3], 1);
            end else begin
                check(m_post_oe == 0, "R3 no hold on read", m_post_oe, 0);
                check(m_rvalid == 1'b1, "R6 rvalid on return", m_rvalid, 1);
                check(m_rdata == v.data, "R6 read data", m_rdata, v.data);
                check(m_status[3] == 1'b0, "R9 write complete cleared", m_status[3], 0);
                @(negedge clk);
                check(host_rvalid == 1'b0, "R6 rvalid one cycle", host_rvalid, 0);
            end
        end

        // R7: second chip select with its own timing word
        cfg_write(6'h20, tword(1'b0, 2'd1, 2'd0, 2'd0, 2'd0));
        cfg_write(6'h24, tword(1'b0, 2'd3, 2'd0, 2'd0, 2'd0));
        cfg_write(6'h00, 32'h0000_0111);
        run_access(1'b1, 5'h10, 8'h42, 8'h00);
        check(m_strobe == 3, "R7 cs1 timing word used", m_strobe, 3);
        check(m_ce == 2'b01, "R7 cs1 pin driven", m_ce, 1);
        cfg_write(6'h00, 32'h0000_0011);
        run_access(1'b1, 5'h10, 8'h42, 8'h00);
        check(m_strobe == 1, "R7 cs0 timing word used", m_strobe, 1);

        // R8: active-high polarity, and no chip enable without address bit 4
        cfg_write(6'h00, 32'h0000_0001);
        @(negedge clk);
        check(nand_ce == 2'b00, "R8 idle ce high-polarity", nand_ce, 0);
        run_access(1'b1, 5'h10, 8'h11, 8'h00);
        check(m_ce == 2'b01, "R8 ce0 active high", m_ce, 1);
        run_access(1'b1, 5'h08, 8'h11, 8'h00);
        check(m_ce == 2'b00 && m_cle, "R1 no ce without bit4", {m_ce, m_cle}, 1);

        // R9: ready/busy follows the pin after two edges
        @(negedge clk);
        nand_rb_n = 1'b0;
        @(negedge clk);
        check(bus_status[0] == 1'b1, "R9 rb not yet through", bus_status[0], 1);
        @(negedge clk);
        check(bus_status[0] == 1'b0, "R9 rb busy seen", bus_status[0], 0);
        nand_rb_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_status[0] == 1'b1, "R9 rb ready seen", bus_status[0], 1);

        // R10: disabled mode short path
        cfg_write(6'h00, 32'h0000_0000);
        run_access(1'b1, 5'h18, 8'hFF, 8'h00);
        check(m_busy == 0 && m_strobe == 0, "R10 write dropped", m_busy, 0);
        check(m_status[3] == 1'b0, "R10 no write complete", m_status[3], 0);
        run_access(1'b0, 5'h10, 8'h00, 8'hEE);
        check(m_busy == 0, "R10 read no stall", m_busy, 0);
        check(m_rvalid == 1'b1 && m_rdata == 8'h00, "R10 read returns zero", m_rdata, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule